// File: doc/BRIEF.md
# Serial Hold Condition Controller

This block sits beside the serial front-end of a four-wire slave port and decides when that front-end must pause. A host can pull the active-low hold line to suspend a transfer in mid-command without deselecting the slave. The block watches the hold line, the serial clock level and the active-low chip select, all sampled in the system clock domain. It grants or releases the pause only at moments when the serial clock is low.

While the pause is granted, the block drives a freeze qualifier. The front-end's bit position stops advancing, and the serial data output is masked to high impedance. The block carries its own bit-position counter, which counts serial clock rising edges. The counter shows that a paused command resumes from the bit where it stopped. If chip select is released during a pause, the block cancels the pause and emits a one-cycle flush strobe that clears the partial command.

The hold line is asynchronous, so it passes through a two-stage synchroniser. Both the pause and release decisions use the synchronised value. The serial clock and chip select arrive already synchronous to the system clock.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `holdActive` is 0, `feFlush` is 0, `bitPos` is 0 and `soOeMask` is 1 while `ceNIn` is high.
- R2: With `ceNIn` low and `sckIn` low, a falling `holdNIn` sets `holdActive` to 1 at the third rising clock edge after the change. Two synchroniser stages plus one decision register give this delay.
- R3: If `sckIn` is high when the synchronised hold line is low, `holdActive` stays 0. It becomes 1 at the first rising clock edge that samples `sckIn` low.
- R4: With `sckIn` low, a rising `holdNIn` clears `holdActive` at the third rising clock edge after the change.
- R5: If `sckIn` is high when the synchronised hold line returns high, `holdActive` stays 1. It clears at the first rising clock edge that samples `sckIn` low.
- R6: While `ceNIn` is high, `holdActive` is 0 whatever `holdNIn` does.
- R7: `bitPos` counts the rising edges of `sckIn` while `ceNIn` is low and wraps modulo 2^`BIT_W`. Rising edges seen while `holdActive` is 1 are not counted, and counting resumes from the same value after the pause ends.
- R8: If `ceNIn` is high while `holdActive` is 1, `feFlush` is 1 in that cycle. At the next clock edge, `holdActive` and `bitPos` both become 0.
- R9: `soOeMask` is 1 (output high impedance) whenever `holdActive` is 1 or `ceNIn` is high, and 0 otherwise.
- R10: `holdActive` stays 1 for as long as `holdNIn` stays low and `ceNIn` stays low, whatever `sckIn` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| holdNIn | input | 1 | Active-low hold line, asynchronous |
| sckIn | input | 1 | Serial clock level, synchronous to clk |
| ceNIn | input | 1 | Active-low chip select, synchronous to clk |
| holdActive | output | 1 | Pause granted; freezes the front-end |
| soOeMask | output | 1 | 1 forces the serial data output to high impedance |
| feFlush | output | 1 | One-cycle strobe: chip select released during a pause |
| bitPos | output | BIT_W | Bit position within the current byte |

## Verification
The assertions assume that `sckIn` and `ceNIn` are clean levels that are already synchronous to `clk`. Only `holdNIn` may change freely. The bench drives every input on the falling clock edge and changes one condition per step. It waits out the synchroniser latency before sampling, so each decision that is checked sees a settled hold level together with a known serial clock level.

// File: rtl/spi_hold_ctrl_pkg.sv
package spi_hold_ctrl_pkg;
  // Strobes the control hands to the datapath
  typedef struct packed {
    logic freeze;   // pause granted: stop counting
    logic flush;    // chip select released during a pause
  } holdStrobes_t;
endpackage

// File: rtl/spi_hold_ctrl_dp.sv
module spi_hold_ctrl_dp
  import spi_hold_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdNIn,
  input  logic             sckIn,
  input  logic             ceNIn,
  input  holdStrobes_t     strobes,
  output logic             holdSync,
  output logic [BIT_W-1:0] bitPos
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   sckPrev;
  logic                   sckRise;

  // Hold line synchroniser; idle level is high
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= holdNIn;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[g] <= 1'b1;
          else       syncChain[g] <= syncChain[g-1];
      end
    end
  endgenerate

  assign holdSync = syncChain[LAST];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckIn;

  assign sckRise = sckIn & ~sckPrev;

  // Bit position: cleared on deselect or flush, frozen while paused
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                                bitPos <= '0;
    else if (ceNIn || strobes.flush)          bitPos <= '0;
    else if (sckRise && !strobes.freeze)      bitPos <= bitPos + 1'b1;

  assert_freeze_holds_pos_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.freeze && !ceNIn) |=> $stable(bitPos));

  assert_flush_clears_pos_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (bitPos == '0));
endmodule

// File: rtl/spi_hold_ctrl_ctl.sv
module spi_hold_ctrl_ctl
  import spi_hold_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         holdSync,
  input  logic         sckIn,
  input  logic         ceNIn,
  output logic         holdActive,
  output holdStrobes_t strobes
);
  logic holdNext;

  // Decisions only at serial-clock-low instants
  always_comb begin
    holdNext = holdActive;
    if (ceNIn)
      holdNext = 1'b0;
    else if (!sckIn)
      holdNext = ~holdSync;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) holdActive <= 1'b0;
    else       holdActive <= holdNext;

  always_comb begin
    strobes.freeze = holdActive;
    strobes.flush  = holdActive & ceNIn;
  end

  assert_entry_at_sck_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> ($past(!sckIn) && $past(!holdSync)));

  assert_exit_at_sck_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdActive) |-> ($past(ceNIn) || $past(!sckIn)));

  assert_idle_when_deselected_R6: assert property (@(posedge clk) disable iff (!rstN)
    ceNIn |=> !holdActive);

  assert_persist_while_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && !holdSync && !ceNIn) |=> holdActive);
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIT_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdNIn,
  input  logic             sckIn,
  input  logic             ceNIn,
  output logic             holdActive,
  output logic             soOeMask,
  output logic             feFlush,
  output logic [BIT_W-1:0] bitPos
);
  holdStrobes_t strobes;
  logic         holdSync;

  spi_hold_ctrl_ctl uCtl (
    .clk(clk), .rstN(rstN), .holdSync(holdSync), .sckIn(sckIn),
    .ceNIn(ceNIn), .holdActive(holdActive), .strobes(strobes)
  );

  spi_hold_ctrl_dp #(.SYNC_STAGES(SYNC_STAGES), .BIT_W(BIT_W)) uDp (
    .clk(clk), .rstN(rstN), .holdNIn(holdNIn), .sckIn(sckIn),
    .ceNIn(ceNIn), .strobes(strobes), .holdSync(holdSync), .bitPos(bitPos)
  );

  assign soOeMask = holdActive | ceNIn;
  assign feFlush  = strobes.flush;

  assert_mask_covers_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> soOeMask);
endmodule

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;
  localparam int BIT_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdNIn = 1'b1;
  logic sckIn = 1'b0;
  logic ceNIn = 1'b1;
  logic holdActive, soOeMask, feFlush;
  logic [BIT_W-1:0] bitPos;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(2), .BIT_W(BIT_W)) uut (
    .clk(clk), .rstN(rstN), .holdNIn(holdNIn), .sckIn(sckIn), .ceNIn(ceNIn),
    .holdActive(holdActive), .soOeMask(soOeMask), .feFlush(feFlush), .bitPos(bitPos)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sckPulse(input int n);
    for (int i = 0; i < n; i++) begin
      sckIn = 1'b1; tick(1);
      sckIn = 1'b0; tick(1);
    end
  endtask

  task automatic deselect();
    holdNIn = 1'b1; sckIn = 1'b0; ceNIn = 1'b1; tick(4);
  endtask

  task automatic testReset();
    check("R1", "holdActive", holdActive, 0);
    check("R1", "feFlush", feFlush, 0);
    check("R1", "bitPos", bitPos, 0);
    check("R1", "soOeMask", soOeMask, 1);
  endtask

  task automatic testEntryExitLow();
    ceNIn = 1'b0; tick(1);
    check("R9", "soOeMask selected", soOeMask, 0);
    holdNIn = 1'b0; tick(2);
    check("R2", "holdActive before latency", holdActive, 0);
    tick(1);
    check("R2", "holdActive after 3 edges", holdActive, 1);
    check("R9", "soOeMask in hold", soOeMask, 1);
    holdNIn = 1'b1; tick(2);
    check("R4", "holdActive before latency", holdActive, 1);
    tick(1);
    check("R4", "holdActive after 3 edges", holdActive, 0);
    deselect();
  endtask

  task automatic testDeferred();
    ceNIn = 1'b0; sckIn = 1'b1; tick(1);
    holdNIn = 1'b0; tick(5);
    check("R3", "entry deferred while sck high", holdActive, 0);
    sckIn = 1'b0; tick(1);
    check("R3", "entry at sck low", holdActive, 1);
    sckIn = 1'b1; tick(1);
    holdNIn = 1'b1; tick(5);
    check("R5", "exit deferred while sck high", holdActive, 1);
    sckIn = 1'b0; tick(1);
    check("R5", "exit at sck low", holdActive, 0);
    deselect();
  endtask

  task automatic testDeselected();
    holdNIn = 1'b0; tick(6);
    check("R6", "hold ignored when deselected", holdActive, 0);
    check("R9", "soOeMask deselected", soOeMask, 1);
    deselect();
  endtask

  task automatic testFreezeResume();
    ceNIn = 1'b0; tick(1);
    sckPulse(3);
    check("R7", "bitPos after 3 edges", bitPos, 3);
    holdNIn = 1'b0; tick(3);
    check("R7", "hold entered", holdActive, 1);
    sckPulse(4);
    check("R7", "bitPos frozen", bitPos, 3);
    check("R10", "hold persists across sck", holdActive, 1);
    holdNIn = 1'b1; tick(3);
    check("R7", "hold released", holdActive, 0);
    sckPulse(2);
    check("R7", "bitPos resumed", bitPos, 5);
    sckPulse(4);
    check("R7", "bitPos wraps", bitPos, 1);
    deselect();
  endtask

  task automatic testFlush();
    ceNIn = 1'b0; tick(1);
    sckPulse(2);
    holdNIn = 1'b0; tick(3);
    check("R8", "hold before flush", holdActive, 1);
    ceNIn = 1'b1; #0.1;
    check("R8", "feFlush strobe", feFlush, 1);
    tick(1);
    check("R8", "holdActive cleared", holdActive, 0);
    check("R8", "feFlush one cycle", feFlush, 0);
    check("R8", "bitPos cleared", bitPos, 0);
    deselect();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    testReset();
    testEntryExitLow();
    testDeferred();
    testDeselected();
    testFreezeResume();
    testFlush();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule